// File: doc/BRIEF.md
# Debt-Repaying Clock-Enable Pacer

The pacer turns the system clock into a stream of one-cycle enable pulses whose long-run rate is `num/den` of the clock. A phase accumulator steps by `num` each cycle and folds back at `den`. Every fold is one pulse owed. A consumer that cannot accept work raises `busy`. While `busy` is high, no pulse goes out and each owed pulse is stored as debt. Once `busy` drops, the pacer pays the debt back by pulsing on every cycle it may use. The long-run average then returns to the programmed rate and downstream timing holds up.

By default the pacer never pulses on two adjacent cycles. This suits logic that needs one idle cycle between enables. The cost is that at exactly half rate the pacer has no spare cycles, so debt taken on then is never repaid. Setting `burst_en` lifts the spacing rule: pulses may run back to back until the debt is cleared. A second output, `cen_half`, marks every other main pulse so that logic at half rate can follow the same pacing. The block has no data path, so it has no valid/ready interface and applies no back-pressure. All pins are plain control levels, sampled on each rising edge.

Top module: `cen_pacer`

## Requirements
- R1: With `busy` low, and with either `burst_en`=1 or 2*`num` <= `den`, the number of `cen` pulses in the first N cycles after reset is floor(N*`num`/`den`). The accumulator starts at 0, adds `num` every cycle and subtracts `den` on reaching it. Cycle k (counting from 0) therefore owes a pulse when floor((k+1)*`num`/`den`) exceeds floor(k*`num`/`den`).
- R2: `cen` is low in every cycle in which `busy` is high, in that same cycle.
- R3: With `burst_en`=0, `cen` is never high on two consecutive cycles.
- R4: A pulse owed in a cycle where it cannot be sent becomes debt. In any cycle with `busy` low and debt non-zero, a pulse goes out if the spacing rule allows it. Once the debt is cleared, the total pulse count again equals the R1 count.
- R5: With `burst_en`=0 and 2*`num` == `den`, debt from a busy period is never repaid. The total stays below the R1 count by the number of pulses owed during busy cycles.
- R6: Debt saturates at 2^DEBT_W-1 (15 by default). Pulses owed beyond that are dropped, so the lasting shortfall is (pulses owed while busy) - 15.
- R7: `cen_half` is high together with the 2nd, 4th, 6th... `cen` pulse after reset, and never without `cen`.
- R8: `rst` is synchronous. While it is high, `cen` and `cen_half` are low. It clears the accumulator, the debt and the `cen_half` phase, so counting per R1 restarts from cycle 0.
- R9: With `num` == `den` and `burst_en`=1, `cen` is high in every cycle in which `busy` is low.
- R10: With `num`=0 and no debt, `cen` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| num | input | ACC_W | Rate numerator |
| den | input | ACC_W | Rate denominator, non-zero |
| busy | input | 1 | Suppresses pulses; owed pulses become debt |
| burst_en | input | 1 | 1 allows pulses on adjacent cycles |
| cen | output | 1 | Main enable pulse |
| cen_half | output | 1 | Enable on every second main pulse |

## Verification
The properties assume that `den` is non-zero, that `num` does not exceed `den`, and that both hold steady between resets. The pacer defines no behaviour for other values. Every stimulus vector meets these limits and asserts reset before it changes the rate. `busy` and `burst_en` may change freely, and the vectors place busy windows so that each one falls at a different phase of the accumulator.

// File: rtl/cen_pacer_pkg.sv
package cen_pacer_pkg;
  // Saturating step of an unsigned counter: +1, -1 or hold.
  function automatic logic [7:0] sat_step(input logic [7:0] v, input logic up,
                                          input logic down, input logic [7:0] top);
    logic [7:0] r;
    r = v;
    if (up && !down) begin
      if (v != top) r = v + 8'd1;
    end else if (down && !up) begin
      if (v != 8'd0) r = v - 8'd1;
    end
    return r;
  endfunction
endpackage

// File: rtl/cen_pacer_phase.sv
module cen_pacer_phase #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] num,
  input  logic [ACC_W-1:0] den,
  output logic             tick
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] den_x;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, num};
    den_x = {1'b0, den};
    tick  = (sum >= den_x);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (tick) begin
      acc_q <= ACC_W'(sum - den_x);
    end else begin
      acc_q <= ACC_W'(sum);
    end
  end
endmodule

// File: rtl/cen_pacer_debt.sv
module cen_pacer_debt #(
  parameter int DEBT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic owe,
  input  logic paid,
  output logic pending
);
  import cen_pacer_pkg::*;

  localparam logic [7:0] DEBT_TOP = 8'((1 << DEBT_W) - 1);

  logic [DEBT_W-1:0] debt_q;
  logic [7:0]        next_w;

  always_comb begin
    next_w  = sat_step(8'(debt_q), owe, paid, DEBT_TOP);
    pending = (debt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) debt_q <= '0;
    else     debt_q <= DEBT_W'(next_w);
  end
endmodule

// File: rtl/cen_pacer_gate.sv
module cen_pacer_gate (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic burst_en,
  input  logic demand,
  output logic cen,
  output logic cen_half
);
  logic last_q;
  logic half_q;
  logic open_w;

  always_comb begin
    open_w   = !rst && !busy && (burst_en || !last_q);
    cen      = open_w && demand;
    cen_half = cen && half_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      last_q <= cen;
      if (cen) half_q <= !half_q;
    end
  end
endmodule

// File: rtl/cen_pacer.sv
module cen_pacer #(
  parameter int ACC_W  = 8,
  parameter int DEBT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] num,
  input  logic [ACC_W-1:0] den,
  input  logic             busy,
  input  logic             burst_en,
  output logic             cen,
  output logic             cen_half
);
  logic tick;
  logic pending;
  logic demand;
  logic owe;
  logic paid;

  cen_pacer_phase #(.ACC_W(ACC_W)) u_phase (
    .clk(clk), .rst(rst), .num(num), .den(den), .tick(tick)
  );

  // A wrap that is not sent this cycle is owed; a pulse with no wrap pays one off.
  always_comb begin
    demand = tick || pending;
    owe    = tick && !cen;
    paid   = cen && !tick;
  end

  cen_pacer_debt #(.DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst(rst), .owe(owe), .paid(paid), .pending(pending)
  );

  cen_pacer_gate u_gate (
    .clk(clk), .rst(rst), .busy(busy), .burst_en(burst_en),
    .demand(demand), .cen(cen), .cen_half(cen_half)
  );
endmodule

// File: rtl/cen_pacer_chk.sv
module cen_pacer_chk #(
  parameter int ACC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] num,
  input logic [ACC_W-1:0] den,
  input logic             busy,
  input logic             burst_en,
  input logic             cen,
  input logic             cen_half
);
  logic half_seen_q;

  always_ff @(posedge clk) begin
    if (rst)      half_seen_q <= 1'b1;
    else if (cen) half_seen_q <= cen_half;
  end

  AST_BUSY_MUTES: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cen); // R2
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (!burst_en && $past(cen)) |-> !cen); // R3
  AST_HALF_WITH_MAIN: assert property (@(posedge clk) disable iff (rst)
    cen_half |-> cen); // R7
  AST_HALF_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    cen |-> (cen_half != half_seen_q)); // R7
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (burst_en && num == den && num != '0 && !busy) |-> cen); // R9

  always_ff @(posedge clk) begin
    if (rst) begin
      AST_RESET_QUIET: assert (!cen && !cen_half); // R8
    end
  end
endmodule

bind cen_pacer cen_pacer_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .num(num), .den(den), .busy(busy),
  .burst_en(burst_en), .cen(cen), .cen_half(cen_half)
);

// File: tb/sim_cen_pacer.sv
module sim_cen_pacer;
  localparam int PERIOD   = 10;
  localparam int DEBT_MAX = 15;
  localparam int WATCHDOG = 150000;
  localparam int NV       = 11;

  typedef struct packed {
    logic [7:0]  n;
    logic [7:0]  d;
    logic        b;
    logic [15:0] bs;
    logic [15:0] bl;
    logic [15:0] len;
  } vec_t;

  // rate n/d, burst mode, busy start, busy length, run length
  localparam vec_t TBL[NV] = '{
    '{8'd1, 8'd3, 1'b0, 16'd0,  16'd0,   16'd90},
    '{8'd3, 8'd7, 1'b1, 16'd10, 16'd20,  16'd120},
    '{8'd1, 8'd3, 1'b0, 16'd12, 16'd15,  16'd150},
    '{8'd5, 8'd6, 1'b1, 16'd5,  16'd10,  16'd100},
    '{8'd1, 8'd2, 1'b0, 16'd6,  16'd6,   16'd60},
    '{8'd1, 8'd2, 1'b1, 16'd6,  16'd6,   16'd60},
    '{8'd1, 8'd1, 1'b1, 16'd0,  16'd0,   16'd40},
    '{8'd0, 8'd5, 1'b1, 16'd3,  16'd4,   16'd40},
    '{8'd1, 8'd4, 1'b1, 16'd10, 16'd100, 16'd200},
    '{8'd7, 8'd9, 1'b1, 16'd20, 16'd12,  16'd100},
    '{8'd2, 8'd5, 1'b0, 16'd0,  16'd0,   16'd75}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] num = 8'd1;
  logic [7:0] den = 8'd1;
  logic       busy = 1'b0;
  logic       burst_en = 1'b0;
  logic       cen;
  logic       cen_half;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cen_pacer u0 (
    .clk(clk), .rst(rst), .num(num), .den(den), .busy(busy),
    .burst_en(burst_en), .cen(cen), .cen_half(cen_half)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int ideal(input int cyc, input int n, input int d);
    return (cyc * n) / d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int d, input logic b);
    @(negedge clk);
    rst = 1'b1; busy = 1'b0; num = 8'(n); den = 8'(d); burst_en = b;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input vec_t v, output int cnt, output int hcnt,
                     output int busy_bad, output int pair_bad);
    logic prev;
    prev = 1'b0;
    cnt = 0; hcnt = 0; busy_bad = 0; pair_bad = 0;
    do_reset(int'(v.n), int'(v.d), v.b);
    for (int k = 0; k < int'(v.len); k++) begin
      busy = (k >= int'(v.bs)) && (k < int'(v.bs) + int'(v.bl));
      #1;
      if (cen) cnt++;
      if (cen_half) hcnt++;
      if (cen_half && !cen) hcnt += 1000;
      if (busy && cen) busy_bad++;
      if (!v.b && prev && cen) pair_bad++;
      prev = cen;
      @(negedge clk);
    end
    busy = 1'b0;
  endtask

  initial begin
    int cnt, hcnt, busy_bad, pair_bad, lost, expv;
    // R8: outputs quiet while reset is held, even at full rate
    num = 8'd1; den = 8'd1; burst_en = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset cen", int'(cen), 0);
    check("R8 reset cen_half", int'(cen_half), 0);

    // Table walk; each vector restarts from reset (R8) and runs to full recovery
    for (int i = 0; i < NV; i++) begin
      run(TBL[i], cnt, hcnt, busy_bad, pair_bad);
      lost = ideal(int'(TBL[i].bs) + int'(TBL[i].bl), int'(TBL[i].n), int'(TBL[i].d))
           - ideal(int'(TBL[i].bs), int'(TBL[i].n), int'(TBL[i].d));
      expv = ideal(int'(TBL[i].len), int'(TBL[i].n), int'(TBL[i].d));
      if (!TBL[i].b && 2 * int'(TBL[i].n) == int'(TBL[i].d)) begin
        expv = expv - lost;                                  // R5
        check("R5 half-rate shortfall", cnt, expv);
      end else if (lost > DEBT_MAX) begin
        expv = expv - (lost - DEBT_MAX);                     // R6
        check("R6 saturated debt", cnt, expv);
      end else if (TBL[i].bl != 0) begin
        check("R4 debt repaid", cnt, expv);
      end else if (TBL[i].n == 0) begin
        check("R10 zero rate", cnt, expv);
      end else if (TBL[i].n == TBL[i].d) begin
        check("R9 full rate", cnt, int'(TBL[i].len));
      end else begin
        check("R1 nominal count", cnt, expv);
      end
      check("R2 busy silences", busy_bad, 0);
      check("R3 spacing", pair_bad, 0);
      check("R7 half count", hcnt, cnt / 2);
    end

    // R3: full rate in spaced mode alternates
    begin
      vec_t v;
      v = '{8'd4, 8'd4, 1'b0, 16'd0, 16'd0, 16'd40};
      run(v, cnt, hcnt, busy_bad, pair_bad);
      check("R3 spaced full rate", cnt, 20);
      check("R3 spaced pairs", pair_bad, 0);
    end

    // R8: reset mid-run restarts the phase (first cycle at 1/3 owes nothing)
    do_reset(1, 3, 1'b0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 restart cycle0", int'(cen), 0);
    @(negedge clk); #1;
    check("R8 restart cycle1", int'(cen), 0);
    @(negedge clk); #1;
    check("R8 restart cycle2", int'(cen), 1);
    check("R7 first pulse not half", int'(cen_half), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=below %0d", WATCHDOG, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule